// File: doc/BRIEF.md
# Half-Precision to Signed 64-bit Truncating Converter

This unit accepts one IEEE binary16 value per cycle and returns the signed 64-bit integer obtained by dropping its fractional part, so the result is always rounded toward zero. Each result comes with two status flags. The inexact flag reports that a nonzero fraction was discarded. The invalid flag reports that the source has no integer value.

Every finite binary16 value lies within ±65504, so only infinities and NaNs are invalid. A mask input chooses the result returned for an invalid source. When the mask is set, the result is the integer indefinite pattern 0x8000_0000_0000_0000. When it is clear, the result is zero and the flag alone carries the event.

The converter has one register stage. It decodes the sign, exponent and mantissa fields, aligns the significand against the binary point and applies the sign in two's complement. The result is registered one cycle after a valid input.

Top module: `fp16_i64_trunc`

## Requirements
- R1: A result, with `out_valid` high, appears on the clock edge after an edge at which `in_valid` is high; `out_valid` is low after any edge at which `in_valid` is low.
- R2: While `in_valid` is low, `out_int`, `flag_invalid` and `flag_inexact` hold their previous values.
- R3: A finite input with magnitude at least 1 yields its integer part, rounded toward zero (2.5 gives 2, 65504 gives 0xFFE0).
- R4: A negative finite input yields the two's-complement negation of the truncated magnitude (-2.5 gives 0xFFFF_FFFF_FFFF_FFFE), and a non-negative finite input never yields a result with bit 63 set.
- R5: `flag_inexact` is high exactly when a nonzero fraction was discarded; an input that is an exact integer leaves it low.
- R6: A subnormal input or a normal input with magnitude below 1 yields 0 with `flag_inexact` high.
- R7: A ±0 input (bits 14:0 all zero) yields 0 with both flags low.
- R8: An input with exponent field 5'h1F (infinity or NaN) raises `flag_invalid`. The result is 0x8000_0000_0000_0000 when `inv_mask` is 1 and 0 when `inv_mask` is 0.
- R9: `flag_invalid` and `flag_inexact` are never high together.
- R10: After reset, `out_valid`, `out_int` and both flags are zero.
- R11: `inv_mask` has no effect on the result or the flags for a non-invalid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Source value present this cycle |
| in_half | input | 16 | binary16 source: sign bit 15, exponent bits 14:10, mantissa bits 9:0 |
| inv_mask | input | 1 | 1 = invalid returns indefinite integer, 0 = invalid returns zero |
| out_valid | output | 1 | Registered result is valid |
| out_int | output | 64 | Signed truncated result |
| flag_invalid | output | 1 | Source was infinity or NaN |
| flag_inexact | output | 1 | Nonzero fraction was discarded |

## Verification
The assertions check on every cycle the one-cycle valid timing, the hold of the outputs between valid inputs, the exclusivity of the two flags, the sign of results from non-negative finite inputs, and the zero result for signed zeros. They also check the result chosen by the mask for an invalid source. The exact integer values and the inexact flag across all magnitudes can only be shown by the bench. It drives a table of boundary encodings and then sweeps all 65536 inputs against an arithmetic model built on division and modulo.

// File: rtl/fp16_i64_pkg.sv
package fp16_i64_pkg;

    parameter int EXP_W = 5;
    parameter int MAN_W = 10;
    parameter int SRC_W = 1 + EXP_W + MAN_W;
    parameter int OUT_W = 64;
    parameter int SIG_W = MAN_W + 1;
    parameter int BIAS  = (1 << (EXP_W - 1)) - 1;
    // exponent field value at which the significand LSB has weight 1
    parameter int LSB_EXP = BIAS + MAN_W;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_TINY    = 2'd1,
        CLS_NORM    = 2'd2,
        CLS_SPECIAL = 2'd3
    } src_class_e;

    typedef struct packed {
        logic             valid;
        logic             masked;
        logic [OUT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } result_t;

endpackage

// File: rtl/fp16_i64_decode.sv
module fp16_i64_decode
    import fp16_i64_pkg::*;
(
    input  logic [SRC_W-1:0] half_i,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [SIG_W-1:0] sig_o,
    output src_class_e       cls_o
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic [MAN_W-1:0] man;

    always_comb begin
        sign_o = half_i[SRC_W-1];
        exp_o  = half_i[SRC_W-2 -: EXP_W];
        man    = half_i[MAN_W-1:0];
        sig_o  = {1'b1, man};
        if (exp_o == EXP_MAX) begin
            cls_o = CLS_SPECIAL;
        end else if (exp_o == '0) begin
            cls_o = (man == '0) ? CLS_ZERO : CLS_TINY;
        end else if (int'(exp_o) < BIAS) begin
            cls_o = CLS_TINY;
        end else begin
            cls_o = CLS_NORM;
        end
    end
endmodule

// File: rtl/fp16_i64_align.sv
module fp16_i64_align
    import fp16_i64_pkg::*;
(
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic [OUT_W-1:0] mag_o,
    output logic             frac_lost_o
);
    logic [OUT_W-1:0] wide;
    logic [OUT_W-1:0] drop_mask;
    int               e;
    int               sh;

    always_comb begin
        wide      = {{(OUT_W-SIG_W){1'b0}}, sig_i};
        e         = int'(exp_i);
        drop_mask = '0;
        sh        = 0;
        if (e >= LSB_EXP) begin
            sh          = e - LSB_EXP;
            mag_o       = wide << sh;
            frac_lost_o = 1'b0;
        end else begin
            sh          = LSB_EXP - e;
            mag_o       = wide >> sh;
            drop_mask   = (OUT_W'(1) << sh) - OUT_W'(1);
            frac_lost_o = |(wide & drop_mask);
        end
    end
endmodule

// File: rtl/fp16_i64_sign.sv
module fp16_i64_sign
    import fp16_i64_pkg::*;
(
    input  logic             neg_i,
    input  logic [OUT_W-1:0] mag_i,
    output logic [OUT_W-1:0] value_o
);
    always_comb begin
        value_o = neg_i ? (~mag_i + OUT_W'(1)) : mag_i;
    end
endmodule

// File: rtl/fp16_i64_trunc.sv
module fp16_i64_trunc
    import fp16_i64_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_half,
    input  logic        inv_mask,
    output logic        out_valid,
    output logic [63:0] out_int,
    output logic        flag_invalid,
    output logic        flag_inexact
);
    localparam logic [OUT_W-1:0] INDEF = {1'b1, {(OUT_W-1){1'b0}}};

    logic             sign;
    logic [EXP_W-1:0] expf;
    logic [SIG_W-1:0] sig;
    src_class_e       cls;
    logic [OUT_W-1:0] mag;
    logic             frac_lost;
    logic [OUT_W-1:0] signed_val;
    result_t          res_d;
    result_t          res_q;

    fp16_i64_decode u_decode (
        .half_i (in_half),
        .sign_o (sign),
        .exp_o  (expf),
        .sig_o  (sig),
        .cls_o  (cls)
    );

    fp16_i64_align u_align (
        .exp_i       (expf),
        .sig_i       (sig),
        .mag_o       (mag),
        .frac_lost_o (frac_lost)
    );

    fp16_i64_sign u_sign (
        .neg_i   (sign),
        .mag_i   (mag),
        .value_o (signed_val)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.masked = inv_mask;
            unique case (cls)
                CLS_ZERO: begin
                    res_d.value   = '0;
                    res_d.invalid = 1'b0;
                    res_d.inexact = 1'b0;
                end
                CLS_TINY: begin
                    res_d.value   = '0;
                    res_d.invalid = 1'b0;
                    res_d.inexact = 1'b1;
                end
                CLS_NORM: begin
                    res_d.value   = signed_val;
                    res_d.invalid = 1'b0;
                    res_d.inexact = frac_lost;
                end
                default: begin
                    res_d.value   = inv_mask ? INDEF : '0;
                    res_d.invalid = 1'b1;
                    res_d.inexact = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_int      = res_q.value;
    assign flag_invalid = res_q.invalid;
    assign flag_inexact = res_q.inexact;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_int) && $stable(flag_invalid) && $stable(flag_inexact))); // R2
    AST_NONNEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_half[15] && (in_half[14:10] != 5'h1F)) |=> !out_int[63]); // R4
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_half[14:0] == '0)) |=> (out_int == '0 && !flag_invalid && !flag_inexact)); // R7
    AST_INDEF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid && res_q.masked) |-> (out_int == INDEF)); // R8
    AST_ZERO_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid && !res_q.masked) |-> (out_int == '0)); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_invalid && flag_inexact)); // R9
endmodule

// File: tb/test_fp16_i64_trunc.sv
module test_fp16_i64_trunc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        inv_mask = 1'b0;
    logic        out_valid;
    logic [63:0] out_int;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fp16_i64_trunc i_fp16_i64_trunc (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_half      (in_half),
        .inv_mask     (inv_mask),
        .out_valid    (out_valid),
        .out_int      (out_int),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    // vector: {half, mask, expected value, invalid, inexact}
    localparam int NV = 16;
    localparam logic [82:0] VEC [NV] = '{
        {16'h3C00, 1'b1, 64'h0000_0000_0000_0001, 1'b0, 1'b0}, // R3 1.0
        {16'h4100, 1'b1, 64'h0000_0000_0000_0002, 1'b0, 1'b1}, // R3 2.5
        {16'hC100, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1}, // R4 -2.5
        {16'h7BFF, 1'b1, 64'h0000_0000_0000_FFE0, 1'b0, 1'b0}, // R3 65504
        {16'hFBFF, 1'b1, 64'hFFFF_FFFF_FFFF_0020, 1'b0, 1'b0}, // R4 -65504
        {16'h3800, 1'b1, 64'h0,                   1'b0, 1'b1}, // R6 0.5
        {16'h0001, 1'b1, 64'h0,                   1'b0, 1'b1}, // R6 subnormal
        {16'h8000, 1'b1, 64'h0,                   1'b0, 1'b0}, // R7 -0
        {16'h7C00, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0}, // R8 +inf masked
        {16'h7E00, 1'b0, 64'h0,                   1'b1, 1'b0}, // R8 NaN unmasked
        {16'hFC00, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0}, // R8 -inf masked
        {16'h3E00, 1'b0, 64'h0000_0000_0000_0001, 1'b0, 1'b1}, // R11 1.5 unmasked
        {16'h6400, 1'b1, 64'h0000_0000_0000_0400, 1'b0, 1'b0}, // R5 1024 exact
        {16'h6800, 1'b0, 64'h0000_0000_0000_0800, 1'b0, 1'b0}, // R5 2048 exact
        {16'hBC00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0}, // R4 -1.0
        {16'h3FFF, 1'b1, 64'h0000_0000_0000_0001, 1'b0, 1'b1}  // R5 1.999
    };
    localparam string TAGS [NV] = '{"R3", "R3", "R4", "R3", "R4", "R6", "R6", "R7",
                                    "R8", "R8", "R8", "R11", "R5", "R5", "R4", "R5"};

    task automatic check(input string tag, input logic [63:0] v, input logic iv,
                         input logic ix, input logic [15:0] h);
        n_checks++;
        if (!out_valid || out_int !== v || flag_invalid !== iv || flag_inexact !== ix) begin
            n_fail++;
            $display("FAIL %s in=%h: got valid=%b val=%h inv=%b inx=%b, expected valid=1 val=%h inv=%b inx=%b",
                     tag, h, out_valid, out_int, flag_invalid, flag_inexact, v, iv, ix);
        end
    endtask

    // drive at negedge; result is registered at the next posedge, sampled at the following negedge
    task automatic apply(input logic [15:0] h, input logic m);
        in_valid = 1'b1;
        in_half  = h;
        inv_mask = m;
        @(negedge clk);
    endtask

    function automatic void model(input logic [15:0] h, input logic m,
                                  output logic [63:0] v, output logic iv,
                                  output logic ix, output string tag);
        int      e;
        longint  s;
        longint  q;
        longint  p;
        e  = int'(h[14:10]);
        iv = 1'b0;
        ix = 1'b0;
        v  = '0;
        if (e == 31) begin
            iv = 1'b1;
            v  = m ? 64'h8000_0000_0000_0000 : 64'h0;
            tag = "R8";
        end else if (h[14:0] == '0) begin
            tag = "R7";
        end else if (e == 0 || e < 15) begin
            ix = 1'b1;
            tag = "R6";
        end else begin
            s = longint'({1'b1, h[9:0]});
            if (e >= 25) begin
                q = s * (longint'(1) <<< (e - 25));
            end else begin
                p  = longint'(1) <<< (25 - e);
                q  = s / p;
                ix = (s % p) != 0;
            end
            v   = h[15] ? 64'(-q) : 64'(q);
            tag = h[15] ? "R4" : "R3";
        end
    endfunction

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [63:0] ev;
        logic        eiv;
        logic        eix;
        string       tg;
        logic [63:0] held;

        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_int !== '0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: got valid=%b val=%h inv=%b inx=%b, expected all zero",
                     out_valid, out_int, flag_invalid, flag_inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][82:67], VEC[i][66]);
            check(TAGS[i], VEC[i][65:2], VEC[i][1], VEC[i][0], VEC[i][82:67]);
        end

        // R11: same input, the other mask setting, same outcome
        apply(16'h4100, 1'b0);
        check("R11", 64'h2, 1'b0, 1'b1, 16'h4100);

        // R1, R2: idle cycle with changed input data
        apply(16'hC100, 1'b1);
        held = out_int;
        in_valid = 1'b0;
        in_half  = 16'h3C00;
        inv_mask = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 out_valid after idle: got %b expected 0", out_valid);
        end
        n_checks++;
        if (out_int !== held || flag_invalid !== 1'b0 || flag_inexact !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 hold: got val=%h inv=%b inx=%b expected val=%h inv=0 inx=1",
                     out_int, flag_invalid, flag_inexact, held);
        end

        // R9 and all value requirements: every encoding, both mask settings alternating
        for (int h = 0; h < 65536; h++) begin
            apply(16'(h), h[0]);
            model(16'(h), h[0], ev, eiv, eix, tg);
            check(tg, ev, eiv, eix, 16'(h));
            if (flag_invalid && flag_inexact) begin
                n_fail++;
                $display("FAIL R9 in=%h: got inv=1 inx=1 expected at most one", h);
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule